// File: doc/BRIEF.md
# Fixed-Vector Interrupt Unit

This block gathers every interrupt source of a processor core and offers the fetch stage one entry address at a time. The sources are:

- 16 channel requests from outside devices.
- 16 input-transfer completions, 16 output-transfer completions and 16 function completions.
- 8 internally detected error types.
- A real-time countdown timer reaching zero.
- An outside synchronization pulse.

Each source has its own fixed entry address. The fetch stage sees `irq_valid` and `irq_vector`. It takes the offered interrupt by raising `irq_accept` for one cycle.

Each source event is a one-cycle strobe that latches a pending flag. The flag is cleared only when its vector is accepted. Taking any interrupt sets a global lockout. The lockout holds back the outside interrupts (channel requests and the synchronization pulse) until the program issues a re-enable strobe. A per-channel enable mask can also hold back channel requests. Error interrupts ignore both the lockout and the mask.

The unit also holds the 36-bit countdown timer. Software can load it and read it back at any moment. It counts down on each tick strobe.

Top module: `intr_vector_unit`

## Requirements
- R1: The fixed vectors are:
  - channel request i: 128+i
  - input completion i: 144+i
  - output completion i: 160+i
  - function completion i: 176+i
  - error i: 192+i
  - timer: 200
  - synchronization: 202
- R2: When several eligible flags are pending, the offered one is chosen in this order:
  - errors first
  - then the timer
  - then synchronization
  - then input, output and function completions, in that order
  - then channel requests

  Within a class, the lowest index wins.
- R3: A pending flag persists across any number of cycles until its vector is accepted. From the cycle after acceptance that source is no longer offered.
- R4: Accepting any interrupt sets the lockout. While the lockout is set, channel requests and synchronization stay pending but are not offered, and the other classes are still offered. An `ext_enable_all` strobe clears the lockout. An accept in the same cycle wins over the strobe.
- R5: `chan_mask` bit i = 1 enables channel request i, and `mask_we` loads it. Reset enables all channels. A masked request stays pending and is offered once its bit is set again.
- R6: Error interrupts are offered whether or not the lockout is set.
- R7: Each `rtc_tick` lowers a non-zero timer by one. The tick that brings the timer from 1 to 0 makes vector 200 pending.
- R8: At zero the timer stays at zero and raises nothing further until it is loaded. A load (`rtc_load`) takes effect on the next cycle and wins over a same-cycle tick. `rtc_value` always shows the current count.
- R9: After reset nothing is pending, the lockout is clear, the timer reads 0 and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_req | input | 16 | Channel request strobes |
| in_done | input | 16 | Input-transfer completion strobes |
| out_done | input | 16 | Output-transfer completion strobes |
| fn_done | input | 16 | Function completion strobes |
| err_evt | input | 8 | Error event strobes |
| sync_pulse | input | 1 | Outside synchronization strobe |
| ext_enable_all | input | 1 | Clears the outside-interrupt lockout |
| mask_we | input | 1 | Loads the channel enable mask |
| chan_mask | input | 16 | New mask, 1 = channel enabled |
| rtc_tick | input | 1 | Timer decrement strobe |
| rtc_load | input | 1 | Timer load strobe |
| rtc_load_val | input | 36 | Value for timer load |
| rtc_value | output | 36 | Current timer count |
| irq_valid | output | 1 | An eligible interrupt is offered |
| irq_vector | output | 8 | Entry address of the offered interrupt |
| irq_accept | input | 1 | Fetch stage takes the offered interrupt |

## Verification
The assertions check the following on every cycle:
- An accept always leaves the lockout set.
- No outside vector is offered while the lockout is set.
- A pending error always owns the offer.
- The timer holds still without a tick or load, steps down by exactly one on a tick, and stays at zero unless loaded.

Only the directed scenarios can show the following:
- The exact address each source maps to.
- The full delivery order when many classes are pending together.
- A masked request being released later.
- The timer's expiry interrupt arriving on the right tick.

// File: rtl/intr_pkg.sv
// Shared definitions for the fixed-vector interrupt unit.
// Source index order (bit 0 first) is also priority order:
//   errors, timer, sync, input, output, function completions, channel requests.
package intr_pkg;
    localparam int VEC_W = 8;
    localparam int EXT_BASE = 128;

    typedef logic [VEC_W-1:0] vec_t;

    // Map a priority-ordered source index to its fixed entry address.
    function automatic vec_t vec_of(input int idx, input int nch, input int nerr);
        int err_base;
        int rest;
        err_base = EXT_BASE + 4 * nch;
        if (idx < nerr) begin
            return VEC_W'(err_base + idx);
        end else if (idx == nerr) begin
            return VEC_W'(err_base + nerr);
        end else if (idx == nerr + 1) begin
            return VEC_W'(err_base + nerr + 2);
        end
        rest = idx - nerr - 2;
        if (rest < 3 * nch) begin
            return VEC_W'(EXT_BASE + nch + rest);
        end
        return VEC_W'(EXT_BASE + rest - 3 * nch);
    endfunction
endpackage

// File: rtl/intr_pend.sv
// Pending-flag bank: each set strobe latches a flag, and each clear bit drops it.
// Assumes set and clear are single-cycle. A same-cycle set wins over a clear.
module intr_pend #(
    parameter int NSRC = 74
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);
    // Hold flags until the granted one is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr) | set;
        end
    end
endmodule

// File: rtl/intr_rtc.sv
// Countdown timer: loads on request, steps down per tick and stops at zero.
// expire is high in the cycle whose tick moves the count from 1 to 0.
module intr_rtc #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         expire
);
    // Load wins over tick; a zero count never wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick && count != '0) begin
            count <= count - W'(1);
        end
    end

    // Flag the tick that reaches zero.
    always_comb expire = tick && !load && (count == W'(1));
endmodule

// File: rtl/intr_arb.sv
// Fixed-priority picker: the lowest set index of elig wins.
// Produces a one-hot grant and the fixed vector of the winner.
module intr_arb
    import intr_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NERR = 8,
    localparam int NSRC = 4 * NCH + NERR + 2
) (
    input  logic [NSRC-1:0] elig,
    output logic            valid,
    output logic [NSRC-1:0] grant,
    output vec_t            vec
);
    // Scan from bit 0 and keep the first eligible source.
    always_comb begin
        valid = 1'b0;
        grant = '0;
        vec   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && !valid) begin
                valid    = 1'b1;
                grant[i] = 1'b1;
                vec      = vec_of(i, NCH, NERR);
            end
        end
    end
endmodule

// File: rtl/intr_vector_unit.sv
// Top of the fixed-vector interrupt unit. It gathers the strobes into pending
// flags, applies the lockout and the channel mask, and offers one vector.
// Assumes all source inputs are single-cycle strobes, synchronous to clk.
module intr_vector_unit
    import intr_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int NERR  = 8,
    parameter int RTC_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   chan_req,
    input  logic [NCH-1:0]   in_done,
    input  logic [NCH-1:0]   out_done,
    input  logic [NCH-1:0]   fn_done,
    input  logic [NERR-1:0]  err_evt,
    input  logic             sync_pulse,
    input  logic             ext_enable_all,
    input  logic             mask_we,
    input  logic [NCH-1:0]   chan_mask,
    input  logic             rtc_tick,
    input  logic             rtc_load,
    input  logic [RTC_W-1:0] rtc_load_val,
    output logic [RTC_W-1:0] rtc_value,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector,
    input  logic             irq_accept
);
    localparam int NSRC = 4 * NCH + NERR + 2;

    logic            rtc_expire;
    logic            lock_q;
    logic [NCH-1:0]  mask_q;
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] allow_v;
    logic [NSRC-1:0] elig_v;
    logic [NSRC-1:0] grant_v;

    intr_rtc #(.W(RTC_W)) u_rtc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (rtc_tick),
        .load     (rtc_load),
        .load_val (rtc_load_val),
        .count    (rtc_value),
        .expire   (rtc_expire)
    );

    // Pack the strobes in priority order, with bit 0 highest.
    always_comb set_v = {chan_req, fn_done, out_done, in_done, sync_pulse, rtc_expire, err_evt};

    intr_pend #(.NSRC(NSRC)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (clr_v),
        .pend  (pend_q)
    );

    // Gate the outside sources by lockout and mask; errors are always allowed.
    always_comb begin
        allow_v = {mask_q & {NCH{~lock_q}}, {(3 * NCH){1'b1}}, ~lock_q, 1'b1, {NERR{1'b1}}};
        elig_v  = pend_q & allow_v;
    end

    intr_arb #(.NCH(NCH), .NERR(NERR)) u_arb (
        .elig  (elig_v),
        .valid (irq_valid),
        .grant (grant_v),
        .vec   (irq_vector)
    );

    // Clear only the granted flag when the fetch stage accepts it.
    always_comb clr_v = grant_v & {NSRC{irq_accept}};

    // Lockout: set by any accept, cleared by the re-enable strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (irq_valid && irq_accept) begin
            lock_q <= 1'b1;
        end else if (ext_enable_all) begin
            lock_q <= 1'b0;
        end
    end

    // Channel enable mask, with all channels enabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= chan_mask;
        end
    end
endmodule

// File: rtl/intr_vector_unit_chk.sv
// Property checker for intr_vector_unit, attached with bind.
// It observes the lockout and the error pending flags inside the top.
module intr_vector_unit_chk #(
    parameter int NCH   = 16,
    parameter int NERR  = 8,
    parameter int RTC_W = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_valid,
    input logic             irq_accept,
    input logic [7:0]       irq_vector,
    input logic             rtc_tick,
    input logic             rtc_load,
    input logic [RTC_W-1:0] rtc_value,
    input logic             lock_q,
    input logic [NERR-1:0]  err_pend
);
    localparam logic [7:0] EXT_HI = 8'(128 + NCH - 1);
    localparam logic [7:0] ERR_LO = 8'(128 + 4 * NCH);
    localparam logic [7:0] ERR_HI = 8'(128 + 4 * NCH + NERR - 1);
    localparam logic [7:0] SYNC_V = 8'(128 + 4 * NCH + NERR + 2);

    // R4
    lock_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_accept) |=> lock_q);

    // R4
    outside_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && irq_valid) |-> (irq_vector > EXT_HI && irq_vector != SYNC_V));

    // R6
    err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_pend) |-> (irq_valid && irq_vector >= ERR_LO && irq_vector <= ERR_HI));

    // R8
    rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtc_load && !rtc_tick) |=> $stable(rtc_value));

    // R8
    rtc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtc_load && rtc_value == '0) |=> (rtc_value == '0));

    // R7
    rtc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_tick && !rtc_load && rtc_value != '0) |=> (rtc_value == $past(rtc_value) - RTC_W'(1)));
endmodule

bind intr_vector_unit intr_vector_unit_chk #(.NCH(NCH), .NERR(NERR), .RTC_W(RTC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_valid  (irq_valid),
    .irq_accept (irq_accept),
    .irq_vector (irq_vector),
    .rtc_tick   (rtc_tick),
    .rtc_load   (rtc_load),
    .rtc_value  (rtc_value),
    .lock_q     (lock_q),
    .err_pend   (pend_q[NERR-1:0])
);

// File: tb/intr_vector_unit_test.sv
// Directed bench for intr_vector_unit: one task per scenario.
// Inputs change and outputs are sampled on the falling edge.
module intr_vector_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] chan_req = '0, in_done = '0, out_done = '0, fn_done = '0;
    logic [7:0]  err_evt = '0;
    logic        sync_pulse = 1'b0, ext_enable_all = 1'b0, mask_we = 1'b0;
    logic [15:0] chan_mask = '0;
    logic        rtc_tick = 1'b0, rtc_load = 1'b0;
    logic [35:0] rtc_load_val = '0;
    logic [35:0] rtc_value;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic        irq_accept = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    intr_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .in_done(in_done),
        .out_done(out_done), .fn_done(fn_done), .err_evt(err_evt),
        .sync_pulse(sync_pulse), .ext_enable_all(ext_enable_all),
        .mask_we(mask_we), .chan_mask(chan_mask), .rtc_tick(rtc_tick),
        .rtc_load(rtc_load), .rtc_load_val(rtc_load_val), .rtc_value(rtc_value),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_accept(irq_accept)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        chan_req = '0; in_done = '0; out_done = '0; fn_done = '0; err_evt = '0;
        sync_pulse = 1'b0; rtc_tick = 1'b0; rtc_load = 1'b0;
    endtask

    // Check the offered vector, then accept it.
    task automatic take(input int exp, input string req);
        chk(irq_valid == 1'b1, req, irq_valid, 1);
        chk(irq_vector == 8'(exp), req, irq_vector, exp);
        irq_accept = 1'b1;
        step();
        irq_accept = 1'b0;
    endtask

    task automatic reopen();
        ext_enable_all = 1'b1;
        step();
        ext_enable_all = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        chk(irq_valid == 1'b0, req, irq_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        expect_idle("R9");
        chk(rtc_value == 0, "R9", rtc_value, 0);
    endtask

    // One source from each class, each reaching its own address.
    task automatic t_map();
        chan_req[5] = 1'b1; step(); clear_strobes();
        take(133, "R1 chan"); reopen();
        in_done[3] = 1'b1; step(); clear_strobes();
        take(147, "R1 in"); reopen();
        out_done[15] = 1'b1; step(); clear_strobes();
        take(175, "R1 out"); reopen();
        fn_done[0] = 1'b1; step(); clear_strobes();
        take(176, "R1 fn"); reopen();
        err_evt[7] = 1'b1; step(); clear_strobes();
        take(199, "R1 err"); reopen();
        sync_pulse = 1'b1; step(); clear_strobes();
        take(202, "R1 sync"); reopen();
        expect_idle("R1 drained");
    endtask

    // Many classes at once: order, lockout and re-enable.
    task automatic t_prio();
        chan_req[2] = 1'b1; fn_done[4] = 1'b1; in_done[1] = 1'b1;
        sync_pulse = 1'b1; err_evt[3] = 1'b1;
        step(); clear_strobes();
        take(195, "R2 err first");
        take(145, "R2 input next");
        take(180, "R2 function next");
        expect_idle("R4 outside held by lockout");
        reopen();
        take(202, "R2 sync before chan");
        expect_idle("R4 chan held after sync");
        reopen();
        take(130, "R4 chan after reopen");
        // Lockout is now set: errors still get through, lowest index first.
        err_evt[5] = 1'b1; err_evt[1] = 1'b1; step(); clear_strobes();
        take(193, "R6 err under lockout");
        take(197, "R6 second err");
        expect_idle("R3 cleared");
        reopen();
    endtask

    task automatic t_hold();
        in_done[7] = 1'b1; step(); clear_strobes();
        for (int i = 0; i < 5; i++) step();
        chk(irq_valid && irq_vector == 8'd151, "R3 held", irq_vector, 151);
        take(151, "R3 accept");
        expect_idle("R3 gone after accept");
        // Accept together with re-enable: the lockout stays set.
        chan_req[9] = 1'b1; fn_done[2] = 1'b1; step(); clear_strobes();
        irq_accept = 1'b1; ext_enable_all = 1'b1;
        step();
        irq_accept = 1'b0; ext_enable_all = 1'b0;
        expect_idle("R4 accept beats reopen");
        reopen();
        take(137, "R4 chan after later reopen");
        reopen();
    endtask

    task automatic t_mask();
        chan_mask = 16'hFFEF; mask_we = 1'b1; step(); mask_we = 1'b0;
        chan_req[4] = 1'b1; step(); clear_strobes();
        step();
        expect_idle("R5 masked");
        chan_mask = 16'hFFFF; mask_we = 1'b1; step(); mask_we = 1'b0;
        take(132, "R5 released");
        reopen();
    endtask

    task automatic t_rtc();
        rtc_load = 1'b1; rtc_load_val = 36'd3; step(); clear_strobes();
        chk(rtc_value == 3, "R8 load", rtc_value, 3);
        rtc_tick = 1'b1; step(); step(); clear_strobes();
        chk(rtc_value == 1, "R7 step", rtc_value, 1);
        expect_idle("R7 not yet");
        rtc_tick = 1'b1; step(); clear_strobes();
        chk(rtc_value == 0, "R7 zero", rtc_value, 0);
        take(200, "R7 expiry vector");
        reopen();
        rtc_tick = 1'b1; step(); step(); clear_strobes();
        chk(rtc_value == 0, "R8 stays zero", rtc_value, 0);
        expect_idle("R8 no repeat");
        rtc_load = 1'b1; rtc_tick = 1'b1; rtc_load_val = 36'hF_0000_000A; step(); clear_strobes();
        chk(rtc_value == 36'hF_0000_000A, "R8 load beats tick", rtc_value, 36'hF_0000_000A);
        rtc_tick = 1'b1; step(); clear_strobes();
        chk(rtc_value == 36'hF_0000_0009, "R7 wide step", rtc_value, 36'hF_0000_0009);
        rtc_load = 1'b1; rtc_load_val = '0; step(); clear_strobes();
        expect_idle("R8 load zero silent");
    endtask

    initial begin
        step();
        t_reset();
        t_map();
        t_prio();
        t_hold();
        t_mask();
        t_rtc();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule